// File: doc/BRIEF.md
# Logic and One-Bit Shift Execute Unit

This block is the bitwise half of a 16-bit integer execute stage. Each valid cycle it takes the current destination register value, a second operand and a function code. The second operand is either a register or an immediate that decode has already formed. The block then produces the value to write back. It covers the four bitwise operations and five single-position shifts. It also holds a one-bit extend flag that survives from one instruction to the next, so software can chain shift-through-extend operations across several words.

The result, the write strobe and the illegal strobe are registered. They appear on the cycle after the valid strobe. Some codes are not handled here. The two carry-based arithmetic codes and every unassigned code raise the illegal strobe instead of writing. A shift code given in register form also raises it.

Top module: `bitop_shift_unit`

## Requirements
- R1: While rst_ni is low, and right after it rises, result_o is 0, wr_o is 0, illegal_o is 0 and ext_o is 0. Reset is asynchronous.
- R2: Codes 0 (AND), 1 (OR), 2 (XOR) and 3 (dst AND NOT operand) are legal in both forms (imm_form_i 0 or 1). They set result_o to the function of dst_i and opnd_i and pulse wr_o, one cycle after valid_i.
- R3: Codes 0 to 3 leave ext_o unchanged.
- R4: Code 6 (shift left, zero fill), immediate form only: result is dst_i shifted left one place with bit 0 = 0, and ext_o takes the old dst_i[15]. opnd_i is ignored.
- R5: Code 7 (shift left through extend), immediate form only: result bit 0 is the old ext_o, the other bits are dst_i[14:0], and ext_o then takes the old dst_i[15].
- R6: Code 8 (arithmetic shift right), immediate form only: bit 15 is replicated, and ext_o takes the old dst_i[0].
- R7: Code 9 (logical shift right), immediate form only: bit 15 becomes 0, and ext_o takes the old dst_i[0].
- R8: Code 10 (shift right through extend), immediate form only: result bit 15 is the old ext_o, the lower bits are dst_i[15:1], and ext_o then takes the old dst_i[0].
- R9: Codes 4, 5 and 11 to 15 in either form, and codes 6 to 10 with imm_form_i = 0, pulse illegal_o for one cycle. For these codes wr_o stays 0, result_o keeps its previous value and ext_o is unchanged.
- R10: In a cycle without valid_i, wr_o and illegal_o are 0 on the next cycle, and result_o and ext_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| imm_form_i | input | 1 | 1 = immediate form, 0 = register form |
| func_i | input | 4 | Function code |
| dst_i | input | 16 | Current destination register value |
| opnd_i | input | 16 | Second operand (register or formed immediate) |
| result_o | output | 16 | Write-back value, registered |
| wr_o | output | 1 | One-cycle strobe: result_o is to be written |
| illegal_o | output | 1 | One-cycle strobe: function code rejected |
| ext_o | output | 1 | Extend flag |

## Verification
In a through-extend shift, the flag is both consumed and reloaded within one operation. The shift must read the old flag as its fill bit, while the same edge loads the bit that is shifted out. The stimulus table makes this happen with alternating fill values, chosen so that ext_o reverses direction each time. Each case has a fill bit that differs from the bit shifted out, so a design that fills with the freshly loaded flag gives a wrong result word. Illegal codes and logic operations are placed between the shifts. This shows that the flag is carried across operations that must not touch it.

// File: rtl/bitop_shift_pkg.sv
package bitop_shift_pkg;
  localparam int unsigned FUNC_W = 4;

  localparam logic [FUNC_W-1:0] FN_AND   = 4'd0;
  localparam logic [FUNC_W-1:0] FN_OR    = 4'd1;
  localparam logic [FUNC_W-1:0] FN_XOR   = 4'd2;
  localparam logic [FUNC_W-1:0] FN_ANDN  = 4'd3;
  localparam logic [FUNC_W-1:0] FN_ADDC  = 4'd4;
  localparam logic [FUNC_W-1:0] FN_SUBC  = 4'd5;
  localparam logic [FUNC_W-1:0] FN_SHL   = 4'd6;
  localparam logic [FUNC_W-1:0] FN_SHLX  = 4'd7;
  localparam logic [FUNC_W-1:0] FN_SHRA  = 4'd8;
  localparam logic [FUNC_W-1:0] FN_SHRL  = 4'd9;
  localparam logic [FUNC_W-1:0] FN_SHRX  = 4'd10;

  typedef enum logic [1:0] {
    K_LOGIC = 2'd0,
    K_SHIFT = 2'd1,
    K_BAD   = 2'd2
  } kind_e;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_shift_pkg::*;
(
  input  logic              imm_form_i,
  input  logic [FUNC_W-1:0] func_i,
  output kind_e             kind_o
);
  always_comb begin
    unique case (func_i)
      FN_AND, FN_OR, FN_XOR, FN_ANDN:
        kind_o = K_LOGIC;
      FN_SHL, FN_SHLX, FN_SHRA, FN_SHRL, FN_SHRX:
        kind_o = imm_form_i ? K_SHIFT : K_BAD; // shifts have no register form
      default:
        kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/bitop_logic.sv
module bitop_logic #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = a_i ^ b_i;
      default: y_o = a_i & ~b_i;
    endcase
  end
endmodule

// File: rtl/bitop_shift.sv
module bitop_shift
  import bitop_shift_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [FUNC_W-1:0] func_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic              ext_i,
  output logic [WIDTH-1:0]  y_o,
  output logic              ext_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic left;
  logic fill;

  always_comb begin
    left = (func_i == FN_SHL) || (func_i == FN_SHLX);
    unique case (func_i)
      FN_SHLX, FN_SHRX: fill = ext_i;
      FN_SHRA:          fill = a_i[MSB];
      default:          fill = 1'b0;
    endcase
  end

  // one-place move, bit by bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign y_o[i] = left ? fill : a_i[i+1];
    end else if (i == MSB) begin : g_hi
      assign y_o[i] = left ? a_i[i-1] : fill;
    end else begin : g_mid
      assign y_o[i] = left ? a_i[i-1] : a_i[i+1];
    end
  end

  assign ext_o = left ? a_i[MSB] : a_i[0];
endmodule

// File: rtl/bitop_shift_unit.sv
module bitop_shift_unit
  import bitop_shift_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              imm_form_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [WIDTH-1:0]  dst_i,
  input  logic [WIDTH-1:0]  opnd_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              wr_o,
  output logic              illegal_o,
  output logic              ext_o
);
  kind_e            kind;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] shift_y;
  logic             shift_ext;

  logic [WIDTH-1:0] result_q;
  logic             wr_q, illegal_q, ext_q;

  bitop_decode u_dec (
    .imm_form_i (imm_form_i),
    .func_i     (func_i),
    .kind_o     (kind)
  );

  bitop_logic #(.WIDTH(WIDTH)) u_logic (
    .sel_i (func_i[1:0]),
    .a_i   (dst_i),
    .b_i   (opnd_i),
    .y_o   (logic_y)
  );

  bitop_shift #(.WIDTH(WIDTH)) u_shift (
    .func_i (func_i),
    .a_i    (dst_i),
    .ext_i  (ext_q),
    .y_o    (shift_y),
    .ext_o  (shift_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q  <= '0;
      wr_q      <= 1'b0;
      illegal_q <= 1'b0;
      ext_q     <= 1'b0;
    end else begin
      wr_q      <= valid_i && (kind != K_BAD);
      illegal_q <= valid_i && (kind == K_BAD);
      if (valid_i) begin
        unique case (kind)
          K_LOGIC: result_q <= logic_y;
          K_SHIFT: begin
            result_q <= shift_y;
            ext_q    <= shift_ext;
          end
          default: ;
        endcase
      end
    end
  end

  assign result_o  = result_q;
  assign wr_o      = wr_q;
  assign illegal_o = illegal_q;
  assign ext_o     = ext_q;
endmodule

// File: rtl/bitop_shift_chk.sv
module bitop_shift_chk
  import bitop_shift_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              imm_form_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [WIDTH-1:0]  dst_i,
  input logic [WIDTH-1:0]  result_o,
  input logic              wr_o,
  input logic              illegal_o,
  input logic              ext_o
);
  localparam int unsigned MSB = WIDTH - 1;

  // R9: the two strobes never coincide
  a_r9_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && illegal_o));

  // R3
  a_r3_logic_keeps_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i <= FN_ANDN) |=> $stable(ext_o));

  // R4
  a_r4_shl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_form_i && func_i == FN_SHL) |=>
      (ext_o == $past(dst_i[MSB])) && (result_o == {$past(dst_i[MSB-1:0]), 1'b0}));

  // R8
  a_r8_shrx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_form_i && func_i == FN_SHRX) |=>
      (result_o[MSB] == $past(ext_o)) && (ext_o == $past(dst_i[0])));

  // R9
  a_r9_carry_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (func_i == FN_ADDC || func_i == FN_SUBC)) |=>
      illegal_o && !wr_o && $stable(result_o) && $stable(ext_o));

  // R10
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_o && !illegal_o && $stable(result_o) && $stable(ext_o));
endmodule

bind bitop_shift_unit bitop_shift_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .imm_form_i (imm_form_i),
  .func_i     (func_i),
  .dst_i      (dst_i),
  .result_o   (result_o),
  .wr_o       (wr_o),
  .illegal_o  (illegal_o),
  .ext_o      (ext_o)
);

// File: tb/sim_bitop_shift_unit.sv
`timescale 1ns/1ps
module sim_bitop_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        imm_form_i = 1'b0;
  logic [3:0]  func_i = '0;
  logic [15:0] dst_i = '0;
  logic [15:0] opnd_i = '0;
  logic [15:0] result_o;
  logic        wr_o, illegal_o, ext_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bitop_shift_unit u0 (
    .clk_i, .rst_ni, .valid_i, .imm_form_i, .func_i,
    .dst_i, .opnd_i, .result_o, .wr_o, .illegal_o, .ext_o
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        imm;
    logic [3:0]  fn;
    logic [15:0] dst;
    logic [15:0] opnd;
    logic [15:0] res;
    logic        wr;
    logic        ill;
    logic        ext;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    {4'd2,  1'b1, 4'd0,  16'hF0F0, 16'h3C3C, 16'h3030, 1'b1, 1'b0, 1'b0}, // R2 AND imm
    {4'd2,  1'b0, 4'd1,  16'h1200, 16'h0034, 16'h1234, 1'b1, 1'b0, 1'b0}, // R2 OR reg
    {4'd2,  1'b0, 4'd2,  16'hFFFF, 16'h0F0F, 16'hF0F0, 1'b1, 1'b0, 1'b0}, // R2 XOR reg
    {4'd2,  1'b1, 4'd3,  16'hABCD, 16'h00FF, 16'hAB00, 1'b1, 1'b0, 1'b0}, // R2 ANDN imm
    {4'd4,  1'b1, 4'd6,  16'h8001, 16'hFFFF, 16'h0002, 1'b1, 1'b0, 1'b1}, // R4
    {4'd3,  1'b1, 4'd0,  16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1}, // R3 ext kept
    {4'd5,  1'b1, 4'd7,  16'h4000, 16'hFFFF, 16'h8001, 1'b1, 1'b0, 1'b0}, // R5
    {4'd8,  1'b1, 4'd10, 16'h0003, 16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b1}, // R8 fill 0
    {4'd8,  1'b1, 4'd10, 16'h0002, 16'h0000, 16'h8001, 1'b1, 1'b0, 1'b0}, // R8 fill 1
    {4'd6,  1'b1, 4'd8,  16'h8003, 16'hFFFF, 16'hC001, 1'b1, 1'b0, 1'b1}, // R6
    {4'd7,  1'b1, 4'd9,  16'h8002, 16'hFFFF, 16'h4001, 1'b1, 1'b0, 1'b0}, // R7
    {4'd9,  1'b1, 4'd4,  16'h1111, 16'h2222, 16'h4001, 1'b0, 1'b1, 1'b0}, // R9 carry-add
    {4'd6,  1'b1, 4'd8,  16'h7FFF, 16'h0000, 16'h3FFF, 1'b1, 1'b0, 1'b1}, // R6 positive
    {4'd9,  1'b0, 4'd5,  16'h0000, 16'h0001, 16'h3FFF, 1'b0, 1'b1, 1'b1}, // R9 carry-sub
    {4'd9,  1'b1, 4'd15, 16'h0000, 16'h0000, 16'h3FFF, 1'b0, 1'b1, 1'b1}, // R9 undefined
    {4'd9,  1'b0, 4'd6,  16'h8000, 16'h0000, 16'h3FFF, 1'b0, 1'b1, 1'b1}, // R9 shift reg form
    {4'd4,  1'b1, 4'd6,  16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b0}, // R4 clears ext
    {4'd9,  1'b1, 4'd11, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0}, // R9 code 11
    {4'd2,  1'b0, 4'd2,  16'h5555, 16'hAAAA, 16'hFFFF, 1'b1, 1'b0, 1'b0}  // R2 XOR
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the capturing edge
  task automatic issue(input logic imm, input logic [3:0] fn,
                       input logic [15:0] d, input logic [15:0] o);
    @(negedge clk_i);
    valid_i = 1'b1; imm_form_i = imm; func_i = fn; dst_i = d; opnd_i = o;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 during reset
    #7;
    chk("R1 result", result_o, 16'h0);
    chk("R1 strobes/ext", {13'd0, wr_o, illegal_o, ext_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release", {result_o[3:0], 9'd0, wr_o, illegal_o, ext_o}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      string t;
      issue(VECS[i].imm, VECS[i].fn, VECS[i].dst, VECS[i].opnd);
      t = $sformatf("R%0d vec%0d", VECS[i].req, i);
      chk({t, " result"}, result_o, VECS[i].res);
      chk({t, " wr/ill/ext"}, {13'd0, wr_o, illegal_o, ext_o},
          {13'd0, VECS[i].wr, VECS[i].ill, VECS[i].ext});
    end

    // R10: idle cycle drops strobes, holds result and ext
    issue(1'b1, 4'd6, 16'h8000, 16'h0);   // R4 sets ext
    chk("R4 set ext", {15'd0, ext_o}, 16'h1);
    @(posedge clk_i); #1;
    chk("R10 idle strobes", {14'd0, wr_o, illegal_o}, 16'h0);
    chk("R10 idle result", result_o, 16'h0000);
    chk("R10 idle ext", {15'd0, ext_o}, 16'h1);

    // R9 illegal pulse is one cycle wide
    issue(1'b1, 4'd12, 16'hFFFF, 16'hFFFF);
    chk("R9 pulse", {14'd0, wr_o, illegal_o}, 16'h1);
    @(posedge clk_i); #1;
    chk("R9 pulse ends", {14'd0, wr_o, illegal_o}, 16'h0);
    chk("R9 ext held", {15'd0, ext_o}, 16'h1);

    // R5 through-extend chain, shift-left fill from held ext
    issue(1'b1, 4'd7, 16'h0000, 16'h0);
    chk("R5 chain result", result_o, 16'h0001);
    chk("R5 chain ext", {15'd0, ext_o}, 16'h0);

    // R1 asynchronous reset mid-run
    issue(1'b1, 4'd9, 16'h0001, 16'h0);   // R7 sets ext
    chk("R7 set ext", {15'd0, ext_o}, 16'h1);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async", {result_o[3:0], 9'd0, wr_o, illegal_o, ext_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule